// File: doc/BRIEF.md
# Floating-Point Rounding and Exception-Flag Control Register

This block holds the control and status state of a single-precision floating-point unit. There are two fields. The first is a 3-bit dynamic rounding mode. The second is a 5-bit set of sticky exception flags. Software reaches the state through one access port that offers three aliased views:

- the whole 32-bit word;
- the rounding field alone, right-aligned;
- the flag field alone, right-aligned.

Each view can be read plainly. Each view can also be swapped: the old contents come back on the read data in the cycle of the access, and the new value is written at the clock edge that ends it.

The arithmetic datapath reports finished operations with an accrue pulse and a 5-bit flag vector. The block ORs that vector into the sticky field. A flag never causes a trap.

The block also resolves the rounding mode that an instruction actually uses. The instruction's 3-bit rounding field either names a static mode or selects the dynamic mode held in the register. Reserved encodings raise an illegal indication. The static field and the stored field each have their own set of reserved values.

Top module: `fpcr_unit`

## Requirements
- R1: After reset the rounding field and the flag field are both zero.
- R2: A read of the full view (view code 00) returns the rounding field in bits 7:5 and the flags in bits 4:0. Bits 31:8 always read as zero.
- R3: A swap on the full view returns the old word. It then loads wdata[7:5] into the rounding field and wdata[4:0] into the flags. Write data bits 31:8 have no effect.
- R4: The rounding view (view code 01) reads the rounding field in bits 2:0, with every other bit zero. A swap on it loads only wdata[2:0] and leaves the flags unchanged.
- R5: The flag view (view code 10) reads the flags in bits 4:0, with every other bit zero. A swap on it loads only wdata[4:0] and leaves the rounding field unchanged. Flag order is: bit 4 invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow, bit 0 inexact.
- R6: A plain read (swap low) changes no state. View code 11 reads as zero and writes nothing.
- R7: An accrue pulse ORs its flag vector into the sticky flags. A flag that is set stays set until a CSR write clears it.
- R8: When a flag-writing swap and an accrue pulse happen in the same cycle, the written value is applied first and the accrued flags are then ORed in.
- R9: Instruction rounding values 000 to 100 pass to the effective mode unchanged, with the illegal indication low. The encodings are: 000 nearest with ties to even, 001 toward zero, 010 downward, 011 upward, 100 nearest with ties away from zero.
- R10: Instruction rounding value 111 makes the effective mode equal to the stored rounding field. The illegal indication is high exactly when the stored value is 101, 110 or 111.
- R11: Instruction rounding values 101 and 110 raise the illegal indication, and the effective mode equals the instruction value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_valid | input | 1 | Access request this cycle |
| csr_view | input | 2 | 00 full word, 01 rounding field, 10 flags, 11 none |
| csr_swap | input | 1 | 1 = swap (read old value, write new value), 0 = plain read |
| csr_wdata | input | 32 | Write data for a swap |
| csr_rdata | output | 32 | Old contents of the selected view (zero when no valid access) |
| acc_valid | input | 1 | Datapath accrue pulse |
| acc_flags | input | 5 | Flags raised by the finished operation |
| instr_rm | input | 3 | Rounding field taken from the instruction |
| eff_rm | output | 3 | Resolved rounding mode |
| rm_illegal | output | 1 | The resolved mode is a reserved encoding |

## Verification
Random swaps with full 32-bit write data in all four view codes show whether each view masks and places its field correctly. They also show whether writes to upper bits leak into the state. Accrue pulses are random, and some coincide with flag writes. Those coincidences tell a correct write-then-OR merge apart from an accrue that is lost or a write that is overridden. Every instruction rounding value is tried against stored modes in both the legal and the reserved range. This separates the static reserved set from the dynamic one. Directed cases cover reset values, swaps that clear all flags, and sticky retention after a pulse.

// File: rtl/fpcr_pkg.sv
package fpcr_pkg;
    localparam int CSR_W   = 32;
    localparam int RM_W    = 3;
    localparam int FLAG_W  = 5;
    localparam int FIELD_W = RM_W + FLAG_W;

    typedef enum logic [1:0] {
        VIEW_FULL  = 2'b00,
        VIEW_RM    = 2'b01,
        VIEW_FLAGS = 2'b10,
        VIEW_NONE  = 2'b11
    } view_e;

    typedef struct packed {
        logic [RM_W-1:0]   rm;
        logic [FLAG_W-1:0] flags;
    } fpcr_state_t;

    localparam logic [RM_W-1:0] RM_DYNAMIC   = 3'b111;
    localparam logic [RM_W-1:0] RM_LAST_MODE = 3'b100;
endpackage

// File: rtl/fpcr_access.sv
module fpcr_access
    import fpcr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid,
    input  logic [1:0]            view,
    input  logic                  swap,
    input  logic [CSR_W-1:0]      wdata,
    input  fpcr_state_t           cur,
    output logic [CSR_W-1:0]      rdata,
    output logic                  wr_rm,
    output logic                  wr_flags,
    output logic [RM_W-1:0]       new_rm,
    output logic [FLAG_W-1:0]     new_flags
);
    view_e sel;
    logic  unused_hi;

    assign sel       = view_e'(view);
    assign unused_hi = ^wdata[CSR_W-1:FIELD_W];

    always_comb begin
        rdata     = '0;
        wr_rm     = 1'b0;
        wr_flags  = 1'b0;
        new_rm    = cur.rm;
        new_flags = cur.flags;
        if (valid) begin
            unique case (sel)
                VIEW_FULL: begin
                    rdata[FIELD_W-1:0] = cur;
                    wr_rm     = swap;
                    wr_flags  = swap;
                    new_rm    = wdata[FIELD_W-1:FLAG_W];
                    new_flags = wdata[FLAG_W-1:0];
                end
                VIEW_RM: begin
                    rdata[RM_W-1:0] = cur.rm;
                    wr_rm  = swap;
                    new_rm = wdata[RM_W-1:0];
                end
                VIEW_FLAGS: begin
                    rdata[FLAG_W-1:0] = cur.flags;
                    wr_flags  = swap;
                    new_flags = wdata[FLAG_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // R2: upper bits of the read data never carry state
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[CSR_W-1:FIELD_W] == '0);

    // R6: a plain read requests no write
    a_r6_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |-> !(wr_rm || wr_flags));
endmodule

// File: rtl/fpcr_rm_resolve.sv
module fpcr_rm_resolve
    import fpcr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RM_W-1:0] instr_rm,
    input  logic [RM_W-1:0] dyn_rm,
    output logic [RM_W-1:0] eff_rm,
    output logic            illegal
);
    logic use_dyn;

    assign use_dyn = (instr_rm == RM_DYNAMIC);

    always_comb begin
        eff_rm  = use_dyn ? dyn_rm : instr_rm;
        illegal = (eff_rm > RM_LAST_MODE);
    end

    // R11: static reserved encodings are reported
    a_r11_static_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_rm == 3'b101 || instr_rm == 3'b110) |-> illegal);

    // R10: dynamic selection with a legal stored mode yields that mode
    a_r10_dyn_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (use_dyn && dyn_rm <= RM_LAST_MODE) |-> (eff_rm == dyn_rm && !illegal));

    // R9: legal static modes pass through
    a_r9_static_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_rm <= RM_LAST_MODE) |-> (eff_rm == instr_rm && !illegal));
endmodule

// File: rtl/fpcr_unit.sv
module fpcr_unit
    import fpcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_valid,
    input  logic [1:0]        csr_view,
    input  logic              csr_swap,
    input  logic [CSR_W-1:0]  csr_wdata,
    output logic [CSR_W-1:0]  csr_rdata,
    input  logic              acc_valid,
    input  logic [FLAG_W-1:0] acc_flags,
    input  logic [RM_W-1:0]   instr_rm,
    output logic [RM_W-1:0]   eff_rm,
    output logic              rm_illegal
);
    fpcr_state_t       st_q, st_d;
    logic              wr_rm, wr_flags;
    logic [RM_W-1:0]   new_rm;
    logic [FLAG_W-1:0] new_flags;

    fpcr_access u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (csr_valid),
        .view      (csr_view),
        .swap      (csr_swap),
        .wdata     (csr_wdata),
        .cur       (st_q),
        .rdata     (csr_rdata),
        .wr_rm     (wr_rm),
        .wr_flags  (wr_flags),
        .new_rm    (new_rm),
        .new_flags (new_flags)
    );

    fpcr_rm_resolve u_resolve (
        .clk      (clk),
        .rst_n    (rst_n),
        .instr_rm (instr_rm),
        .dyn_rm   (st_q.rm),
        .eff_rm   (eff_rm),
        .illegal  (rm_illegal)
    );

    always_comb begin
        st_d = st_q;
        if (wr_rm)     st_d.rm    = new_rm;
        if (wr_flags)  st_d.flags = new_flags;
        if (acc_valid) st_d.flags = st_d.flags | acc_flags;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: flags are sticky unless software writes them
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_flags |=> ((st_q.flags & $past(st_q.flags)) == $past(st_q.flags)));

    // R8: an accrued flag is present after the edge even under a write
    a_r8_accrue_wins: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> ((st_q.flags & $past(acc_flags)) == $past(acc_flags)));

    // R4: rounding field holds when not written
    a_r4_rm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_rm |=> $stable(st_q.rm));
endmodule

// File: tb/fpcr_unit_tb.sv
module fpcr_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        csr_valid;
    logic [1:0]  csr_view;
    logic        csr_swap;
    logic [31:0] csr_wdata;
    logic [31:0] csr_rdata;
    logic        acc_valid;
    logic [4:0]  acc_flags;
    logic [2:0]  instr_rm;
    logic [2:0]  eff_rm;
    logic        rm_illegal;

    int checks = 0;
    int errors = 0;
    logic [2:0] m_rm;
    logic [4:0] m_fl;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpcr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_view(csr_view),
        .csr_swap(csr_swap), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .acc_valid(acc_valid), .acc_flags(acc_flags), .instr_rm(instr_rm),
        .eff_rm(eff_rm), .rm_illegal(rm_illegal)
    );

    function automatic logic [31:0] exp_rdata(logic v, logic [1:0] vw, logic [2:0] r, logic [4:0] f);
        if (!v) return 32'h0;
        case (vw)
            2'b00:   return {24'h0, r, f};
            2'b01:   return {29'h0, r};
            2'b10:   return {27'h0, f};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [2:0] exp_eff(logic [2:0] irm, logic [2:0] r);
        return (irm == 3'b111) ? r : irm;
    endfunction

    function automatic logic exp_ill(logic [2:0] irm, logic [2:0] r);
        logic [2:0] e = (irm == 3'b111) ? r : irm;
        return e >= 3'b101;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, check outputs, then commit the model at the edge
    task automatic step(logic v, logic [1:0] vw, logic sw, logic [31:0] wd,
                        logic av, logic [4:0] af, logic [2:0] irm);
        string tag;
        @(negedge clk);
        csr_valid = v; csr_view = vw; csr_swap = sw; csr_wdata = wd;
        acc_valid = av; acc_flags = af; instr_rm = irm;
        #1;
        tag = (vw == 2'b00) ? "R2/R3" : (vw == 2'b01) ? "R4" : (vw == 2'b10) ? "R5" : "R6";
        check(tag, csr_rdata, exp_rdata(v, vw, m_rm, m_fl));
        tag = (irm == 3'b111) ? "R10" : (irm > 3'b100) ? "R11" : "R9";
        check(tag, {29'h0, eff_rm}, {29'h0, exp_eff(irm, m_rm)});
        check(tag, {31'h0, rm_illegal}, {31'h0, exp_ill(irm, m_rm)});
        @(posedge clk);
        if (v && sw) begin
            if (vw == 2'b00) begin m_rm = wd[7:5]; m_fl = wd[4:0]; end
            if (vw == 2'b01) m_rm = wd[2:0];
            if (vw == 2'b10) m_fl = wd[4:0];
        end
        if (av) m_fl = m_fl | af;
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; csr_valid = 0; csr_view = 0; csr_swap = 0; csr_wdata = 0;
        acc_valid = 0; acc_flags = 0; instr_rm = 0;
        m_rm = 0; m_fl = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: reset state seen through the full view
        @(negedge clk); csr_valid = 1; csr_view = 2'b00; #1;
        check("R1", csr_rdata, 32'h0);
        // R3: upper write bits ignored
        step(1, 2'b00, 1, 32'hFFFF_FF6A, 0, 5'h0, 3'b000);
        step(1, 2'b00, 0, 32'h0, 0, 5'h0, 3'b111);
        // R4: rounding view write leaves flags
        step(1, 2'b01, 1, 32'hFFFF_FFF1, 0, 5'h0, 3'b111);
        step(1, 2'b00, 0, 32'h0, 0, 5'h0, 3'b111);
        // R5: flag view write leaves rounding
        step(1, 2'b10, 1, 32'hFFFF_FFE0, 0, 5'h0, 3'b111);
        step(1, 2'b00, 0, 32'h0, 0, 5'h0, 3'b010);
        // R7: sticky accrual
        step(0, 2'b00, 0, 32'h0, 1, 5'b10000, 3'b000);
        step(0, 2'b00, 0, 32'h0, 1, 5'b00001, 3'b000);
        step(1, 2'b10, 0, 32'h0, 0, 5'h0, 3'b000);
        // R8: clearing write collides with accrue
        step(1, 2'b10, 1, 32'h0, 1, 5'b00100, 3'b000);
        step(1, 2'b10, 0, 32'h0, 0, 5'h0, 3'b000);
        // R6: view 11 swap and plain read change nothing
        step(1, 2'b11, 1, 32'hFFFF_FFFF, 0, 5'h0, 3'b000);
        step(1, 2'b00, 0, 32'hFFFF_FFFF, 0, 5'h0, 3'b000);
        // R10: stored reserved modes under dynamic selection
        for (int k = 0; k < 8; k++) begin
            step(1, 2'b01, 1, 32'(k), 0, 5'h0, 3'b111);
            step(0, 2'b00, 0, 32'h0, 0, 5'h0, 3'b111);
        end
        // R9/R11: every static value
        for (int k = 0; k < 7; k++) step(0, 2'b00, 0, 32'h0, 0, 5'h0, 3'(k));
        // random mix
        for (int i = 0; i < 400; i++) begin
            step($urandom_range(0, 3) != 0, 2'($urandom), $urandom_range(0, 1) == 1,
                 $urandom, $urandom_range(0, 2) == 0, 5'($urandom), 3'($urandom));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule